// File: doc/BRIEF.md
# Stuck-Cell LLR Erasure Unit

This unit sits in the read path of a multi-level flash controller, between the LLR generator and a soft-decision LDPC decoder. Each cell holds two bits. Every cycle the unit can accept one cell. For that cell it takes the hard-decision voltage level and the two signed LLRs of its bits. Alongside the cells runs a compressed stream of stuck-location bits, which was recorded when the page was written.

The write side only recorded a location bit for cells whose read-back sits at the top voltage level. The unit works out the same side information again on read. It takes one location bit from the stream only for a top-level cell. For every other cell it decides "not stuck" without touching the stream. When a cell is flagged as stuck, both of its LLRs are replaced by an erasure value. That value is zero by default. In bias mode it is instead a signed value of magnitude α·ln2, whose signs follow the top level's Gray code. All other LLRs pass through unchanged, after one register stage and in their original order.

Each page's location stream ends with a bit marked as final. The unit reports when a page needs more bits than its stream holds. It also reports when a page ends while its stream still has unread bits.

Top module: `stuck_llr_eraser`

## Requirements
- R1: The level code is 2'b00..2'b11 for levels L1..L4, with L4 = 2'b11 the top level. A cell whose level is not L4 never asserts `loc_pop`, is never erased, and its two LLRs come out unchanged.
- R2: A valid L4 cell asserts `loc_pop` in the same cycle when a bit of the current page is available. That bit becomes the cell's stuck flag, where 1 means stuck.
- R3: A stuck cell with `cfg_bias_en`=0 outputs 0 on both `out_llr_even` and `out_llr_odd`.
- R4: A stuck cell with `cfg_bias_en`=1 outputs −M on `out_llr_even` and +M on `out_llr_odd`. The top-level Gray code 10 has a 1 on the even bit and a 0 on the odd bit, and a positive LLR favours 0. M = min(floor(`cfg_alpha`·177/256), 2^(LLR_W−1)−1).
- R5: An L4 cell whose popped bit is 0 is not erased and keeps both LLRs unchanged.
- R6: Every accepted cell appears on the outputs exactly one clock later, with `out_valid`, `out_last` and `out_erased` aligned to it. An idle input cycle gives an idle output cycle.
- R7: An L4 cell whose page stream is exhausted gets `err_underrun`=1 on its output cycle. This happens when `loc_valid`=0, or when the bit marked final was already taken in this page. Such a cell does not pop, is not erased and passes its LLRs through.
- R8: The last cell of a page gets `err_leftover`=1 when the page's final-marked bit has not been consumed by the end of that cell and a bit is still waiting.
- R9: After a page's last cell, the stream-exhausted state clears, so the first L4 cell of the next page pops again.
- R10: While reset is held and right after it, `out_valid`, `out_erased`, `err_underrun` and `err_leftover` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bias_en | input | 1 | 1 selects signed-bias erasure, 0 selects zero erasure |
| cfg_alpha | input | ALPHA_W | Unsigned scale α used for the bias magnitude |
| in_valid | input | 1 | A cell is presented this cycle |
| in_level | input | 2 | Hard-decision level of the cell |
| in_llr_even | input | LLR_W | Signed LLR of the cell's bit 2j |
| in_llr_odd | input | LLR_W | Signed LLR of the cell's bit 2j+1 |
| in_last | input | 1 | Last cell of the page |
| loc_valid | input | 1 | A location bit is waiting |
| loc_bit | input | 1 | The waiting location bit |
| loc_last | input | 1 | The waiting bit is the page's final one |
| loc_pop | output | 1 | The waiting location bit is consumed this cycle |
| out_valid | output | 1 | Output cell valid |
| out_llr_even | output | LLR_W | LLR of bit 2j after erasure |
| out_llr_odd | output | LLR_W | LLR of bit 2j+1 after erasure |
| out_last | output | 1 | Output cell ends the page |
| out_erased | output | 1 | Output cell was treated as stuck |
| err_underrun | output | 1 | Location stream ran dry for this cell |
| err_leftover | output | 1 | Page ended with location bits still unread |

## Verification
The only hidden state is the flag saying that the page's stream has ended. If it is wrong, the fault shows up at the very next L4 cell: either `loc_pop` goes missing and a false underrun appears, or an extra pop pulls in a bit belonging to the next page. Either way, every later cell of that page and of the following one is erased against the wrong bit. The output register adds a fixed one-cycle delay. A mistake in alignment or in the bias arithmetic therefore shows up on the LLR ports of the same cell, one clock after it was presented.

// File: rtl/stuck_erase_pkg.sv
package stuck_erase_pkg;

  // Voltage levels as delivered by the hard-decision slicer.
  typedef enum logic [1:0] {
    LVL_1 = 2'b00,
    LVL_2 = 2'b01,
    LVL_3 = 2'b10,
    LVL_4 = 2'b11
  } lvl_e;

  // Gray code stored in the top level: bit 2j first, bit 2j+1 second.
  localparam logic [1:0] TOP_GRAY = 2'b10;

  // ln(2) in Q8 fixed point.
  localparam int unsigned LN2_Q8 = 177;

  // Bias magnitude alpha*ln2, truncated and clipped to the LLR range.
  function automatic int unsigned scaled_bias(int unsigned alpha, int unsigned cap);
    int unsigned raw;
    raw = (alpha * LN2_Q8) >> 8;
    return (raw > cap) ? cap : raw;
  endfunction

endpackage

// File: rtl/loc_flag_recover.sv
module loc_flag_recover
  import stuck_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_valid,
  input  logic [1:0] cell_level,
  input  logic       cell_last,
  input  logic       loc_valid,
  input  logic       loc_bit,
  input  logic       loc_last,
  output logic       loc_pop,
  output logic       cell_stuck,
  output logic       underrun,
  output logic       leftover
);

  logic stream_done;   // page's final location bit already consumed
  logic need_bit;      // side information v = 1 for this cell
  logic bit_avail;
  logic done_next;

  assign need_bit   = cell_valid && (lvl_e'(cell_level) == LVL_4);
  assign bit_avail  = loc_valid && !stream_done;
  assign loc_pop    = need_bit && bit_avail;
  assign cell_stuck = loc_pop && loc_bit;
  assign underrun   = need_bit && !bit_avail;
  assign done_next  = stream_done || (loc_pop && loc_last);
  assign leftover   = cell_valid && cell_last && !done_next && bit_avail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stream_done <= 1'b0;
    end else if (cell_valid) begin
      stream_done <= cell_last ? 1'b0 : done_next;
    end
  end

  AST_POP_ONLY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    loc_pop |-> (cell_valid && cell_level == 2'b11)); // R1
  AST_STUCK_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    cell_stuck |-> (loc_pop && loc_bit)); // R2
  AST_UNDERRUN_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !loc_pop); // R7
  AST_PAGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_last) |=> !stream_done); // R9

endmodule

// File: rtl/bias_gen.sv
module bias_gen
  import stuck_erase_pkg::*;
#(
  parameter int LLR_W   = 6,
  parameter int ALPHA_W = 6
) (
  input  logic [ALPHA_W-1:0] alpha,
  output logic [LLR_W-1:0]   mag
);

  localparam int unsigned MAXPOS = (1 << (LLR_W - 1)) - 1;

  assign mag = LLR_W'(scaled_bias(32'(alpha), MAXPOS));

endmodule

// File: rtl/llr_eraser.sv
module llr_eraser
  import stuck_erase_pkg::*;
#(
  parameter int LLR_W = 6
) (
  input  logic signed [LLR_W-1:0] llr_even,
  input  logic signed [LLR_W-1:0] llr_odd,
  input  logic                    stuck,
  input  logic                    bias_en,
  input  logic        [LLR_W-1:0] bias_mag,
  output logic signed [LLR_W-1:0] res_even,
  output logic signed [LLR_W-1:0] res_odd
);

  localparam int NBIT = 2;

  logic signed [LLR_W-1:0] llr_in  [NBIT];
  logic signed [LLR_W-1:0] llr_res [NBIT];
  logic signed [LLR_W-1:0] pos_mag;
  logic signed [LLR_W-1:0] neg_mag;

  assign llr_in[0] = llr_even;
  assign llr_in[1] = llr_odd;
  assign pos_mag   = bias_mag;
  assign neg_mag   = -pos_mag;

  for (genvar i = 0; i < NBIT; i++) begin : g_bit
    // A stored 1 wants a negative LLR, a stored 0 a positive one.
    localparam logic CODE_BIT = TOP_GRAY[NBIT-1-i];
    always_comb begin
      if (!stuck)        llr_res[i] = llr_in[i];
      else if (!bias_en) llr_res[i] = '0;
      else               llr_res[i] = CODE_BIT ? neg_mag : pos_mag;
    end
  end

  assign res_even = llr_res[0];
  assign res_odd  = llr_res[1];

endmodule

// File: rtl/stuck_llr_eraser.sv
module stuck_llr_eraser
  import stuck_erase_pkg::*;
#(
  parameter int LLR_W   = 6,
  parameter int ALPHA_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_bias_en,
  input  logic [ALPHA_W-1:0]      cfg_alpha,
  input  logic                    in_valid,
  input  logic [1:0]              in_level,
  input  logic signed [LLR_W-1:0] in_llr_even,
  input  logic signed [LLR_W-1:0] in_llr_odd,
  input  logic                    in_last,
  input  logic                    loc_valid,
  input  logic                    loc_bit,
  input  logic                    loc_last,
  output logic                    loc_pop,
  output logic                    out_valid,
  output logic signed [LLR_W-1:0] out_llr_even,
  output logic signed [LLR_W-1:0] out_llr_odd,
  output logic                    out_last,
  output logic                    out_erased,
  output logic                    err_underrun,
  output logic                    err_leftover
);

  logic                    cell_stuck;
  logic                    underrun;
  logic                    leftover;
  logic [LLR_W-1:0]        bias_mag;
  logic signed [LLR_W-1:0] res_even;
  logic signed [LLR_W-1:0] res_odd;

  loc_flag_recover u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_valid (in_valid),
    .cell_level (in_level),
    .cell_last  (in_last),
    .loc_valid  (loc_valid),
    .loc_bit    (loc_bit),
    .loc_last   (loc_last),
    .loc_pop    (loc_pop),
    .cell_stuck (cell_stuck),
    .underrun   (underrun),
    .leftover   (leftover)
  );

  bias_gen #(.LLR_W(LLR_W), .ALPHA_W(ALPHA_W)) u_bias (
    .alpha (cfg_alpha),
    .mag   (bias_mag)
  );

  llr_eraser #(.LLR_W(LLR_W)) u_erase (
    .llr_even (in_llr_even),
    .llr_odd  (in_llr_odd),
    .stuck    (cell_stuck),
    .bias_en  (cfg_bias_en),
    .bias_mag (bias_mag),
    .res_even (res_even),
    .res_odd  (res_odd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_llr_even <= '0;
      out_llr_odd  <= '0;
      out_last     <= 1'b0;
      out_erased   <= 1'b0;
      err_underrun <= 1'b0;
      err_leftover <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_llr_even <= res_even;
      out_llr_odd  <= res_odd;
      out_last     <= in_valid && in_last;
      out_erased   <= cell_stuck;
      err_underrun <= underrun;
      err_leftover <= leftover;
    end
  end

  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R6
  AST_IDLE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R6
  AST_ZERO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cell_stuck && !cfg_bias_en) |=> (out_llr_even == 0 && out_llr_odd == 0)); // R3
  AST_BIAS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cell_stuck && cfg_bias_en) |=> (out_llr_even <= 0 && out_llr_odd >= 0)); // R4
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cell_stuck) |=> (out_llr_even == $past(in_llr_even) && out_llr_odd == $past(in_llr_odd))); // R5
  AST_UNDERRUN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    err_underrun |-> (out_valid && !out_erased)); // R7
  AST_LEFTOVER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    err_leftover |-> (out_valid && out_last)); // R8

endmodule

// File: tb/sim_stuck_llr_eraser.sv
module sim_stuck_llr_eraser;
  localparam int CLK_P = 10;
  localparam int W     = 6;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_bias_en = 1'b0;
  logic [AW-1:0] cfg_alpha = '0;
  logic in_valid = 1'b0;
  logic [1:0] in_level = '0;
  logic signed [W-1:0] in_llr_even = '0;
  logic signed [W-1:0] in_llr_odd = '0;
  logic in_last = 1'b0;
  logic loc_valid, loc_bit, loc_last, loc_pop;
  logic out_valid, out_last, out_erased, err_underrun, err_leftover;
  logic signed [W-1:0] out_llr_even, out_llr_odd;

  logic strm [64];
  int strm_len = 0;
  int strm_end = -1;
  int ptr = 0;
  bit m_done = 1'b0;
  int total = 0;
  int bad = 0;

  assign loc_valid = ptr < strm_len;
  assign loc_bit   = strm[ptr[5:0]];
  assign loc_last  = (ptr == strm_end);

  always #(CLK_P/2) clk = ~clk;

  stuck_llr_eraser #(.LLR_W(W), .ALPHA_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_bias_en(cfg_bias_en), .cfg_alpha(cfg_alpha),
    .in_valid(in_valid), .in_level(in_level), .in_llr_even(in_llr_even),
    .in_llr_odd(in_llr_odd), .in_last(in_last), .loc_valid(loc_valid),
    .loc_bit(loc_bit), .loc_last(loc_last), .loc_pop(loc_pop),
    .out_valid(out_valid), .out_llr_even(out_llr_even), .out_llr_odd(out_llr_odd),
    .out_last(out_last), .out_erased(out_erased), .err_underrun(err_underrun),
    .err_leftover(err_leftover));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 magnitude: alpha*ln2 in Q8, rounded down, clipped at the largest positive LLR.
  function automatic int exp_mag(int alpha);
    int m = (alpha * 177) / 256;
    int top = 2 ** (W - 1) - 1;
    return (m > top) ? top : m;
  endfunction

  task automatic load_stream(int nbits, int boundary, int pat);
    for (int i = 0; i < 64; i++) strm[i] = ((pat >> (i % 16)) & 1) != 0;
    strm_len = nbits;
    strm_end = boundary;
    ptr = 0;
  endtask

  task automatic send_cell(int lvl, int a, int b, bit last, string ptag);
    bit need, avail, epop, flag, eund, eleft, dnext;
    int ea, eb;
    @(negedge clk);
    in_valid = 1'b1; in_level = 2'(lvl);
    in_llr_even = W'(a); in_llr_odd = W'(b); in_last = last;
    #1;
    need  = (lvl == 3);
    avail = (ptr < strm_len) && !m_done;
    epop  = need && avail;
    flag  = epop && strm[ptr[5:0]];
    eund  = need && !avail;
    dnext = m_done || (epop && ptr == strm_end);
    eleft = last && !dnext && avail;
    if (flag) begin
      ea = cfg_bias_en ? -exp_mag(int'(cfg_alpha)) : 0;
      eb = cfg_bias_en ?  exp_mag(int'(cfg_alpha)) : 0;
    end else begin
      ea = a; eb = b;
    end
    check(ptag, int'(loc_pop), int'(epop));
    @(posedge clk);
    #1;
    if (epop) ptr++;
    m_done = last ? 1'b0 : dnext;
    in_valid = 1'b0;
    check("R6 valid", int'(out_valid), 1);
    check("R6 last", int'(out_last), int'(last));
    check(flag ? (cfg_bias_en ? "R4 even" : "R3 even") : (need ? "R5 even" : "R1 even"),
          int'(out_llr_even), ea);
    check(flag ? (cfg_bias_en ? "R4 odd" : "R3 odd") : (need ? "R5 odd" : "R1 odd"),
          int'(out_llr_odd), eb);
    check("R2 erased", int'(out_erased), int'(flag));
    check("R7 underrun", int'(err_underrun), int'(eund));
    check("R8 leftover", int'(err_leftover), int'(eleft));
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R6 idle", int'(out_valid), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vals[5] = '{-32, -7, 0, 5, 31};
    int alphas[5] = '{0, 20, 37, 45, 63};
    int pats[5] = '{16'h5A5A, 16'hFFFF, 16'h3C96, 16'hA5C3, 16'h0F0F};
    load_stream(0, -1, 0);
    repeat (3) @(posedge clk);
    #1;
    check("R10 valid", int'(out_valid), 0);
    check("R10 erased", int'(out_erased), 0);
    check("R10 err", int'(err_underrun | err_leftover), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R10 after", int'(out_valid | err_underrun | err_leftover), 0);

    // Full pages: every level against every LLR value, both modes, several alphas.
    for (int cfg = 0; cfg < 10; cfg++) begin
      int k = 0;
      cfg_bias_en = (cfg % 2) != 0;
      cfg_alpha = AW'(alphas[cfg / 2]);
      load_stream(5, 4, pats[cfg / 2] >> (cfg % 2));
      for (int lv = 0; lv < 4; lv++) begin
        for (int vi = 0; vi < 5; vi++) begin
          k++;
          send_cell(lv, vals[vi], vals[4 - vi], k == 20, lv == 3 ? "R2 pop" : "R1 pop");
        end
      end
      idle_cycle();
    end

    // Underrun: stream shorter than the number of L4 cells.
    cfg_bias_en = 1'b0;
    load_stream(1, 0, 16'h0001);
    send_cell(3, 9, -9, 1'b0, "R2 pop");
    send_cell(3, 4, -4, 1'b0, "R7 pop");
    send_cell(0, 3, 3, 1'b1, "R1 pop");

    // Underrun after the final bit with next-page bits waiting, then restart.
    cfg_bias_en = 1'b1; cfg_alpha = AW'(30);
    load_stream(4, 1, 16'h000F);
    send_cell(3, 2, 2, 1'b0, "R2 pop");
    send_cell(3, 2, 2, 1'b0, "R2 pop");
    send_cell(3, 6, -1, 1'b0, "R7 pop");
    send_cell(2, 1, 1, 1'b1, "R1 pop");
    strm_end = 3;
    send_cell(3, -5, 7, 1'b0, "R9 pop");
    send_cell(3, -5, 7, 1'b1, "R9 pop");

    // Leftover: more bits than L4 cells.
    load_stream(3, 2, 16'h0005);
    send_cell(3, 1, 1, 1'b0, "R2 pop");
    send_cell(1, 1, 1, 1'b1, "R8 pop");
    load_stream(2, 1, 16'h0002);
    send_cell(3, 8, 8, 1'b1, "R8 pop");

    // Empty page with an empty stream: no errors.
    load_stream(0, -1, 0);
    send_cell(0, 12, -12, 1'b0, "R1 pop");
    send_cell(2, -12, 12, 1'b1, "R1 pop");
    idle_cycle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule